// File: doc/BRIEF.md
# Two-Throw Contact Debouncer

This block cleans up a bank of mechanical changeover switches. Each switch has two contact lines, both active low: one is pulled low while the leaf rests on the "high" throw and the other while it rests on the "low" throw. Because the leaf breaks one contact before it makes the other, the block can work as a set-reset latch. The first touch on a throw sets the output at once. The open interval and any bounce that follows change nothing. No stable-time counter is needed, so the only delay is the input synchroniser.

Each contact line first passes through a synchroniser chain of `SYNC_STAGES` flops, which idles high. Per channel, a registered latch then decodes the pair of lines. Every output transition can raise a one-cycle change strobe; this strobe is an option chosen at elaboration. A rare state with both contacts low is treated as illegal: the output holds and an error pulse is raised. A synchronous reset loads the per-channel default levels from `RST_LEVEL`.

Top module: `sw2t_debounce`

## Requirements
- R1: While `rst` is high at a clock edge, `level_o` takes `RST_LEVEL` and `change_o` and `clash_o` go to 0. The synchronisers reload the idle-high state.
- R2: `throw_hi_n[i]`=0 with `throw_lo_n[i]`=1 makes `level_o[i]`=1. The output changes at the edge `SYNC_STAGES`+1 after the input change, and one edge earlier it still shows the old level.
- R3: `throw_lo_n[i]`=0 with `throw_hi_n[i]`=1 makes `level_o[i]`=0, with the same latency and no extra wait.
- R4: With both lines of a channel high (leaf in transit), `level_o[i]` holds its value.
- R5: A bounce that opens a contact and then makes the same throw again leaves `level_o[i]` unchanged and raises no strobe.
- R6: With `STROBE_EN`=1, `change_o[i]` is 1 for exactly the cycle in which `level_o[i]` shows a new value, and 0 in every other cycle.
- R7: With both synchronised lines of a channel low, `level_o[i]` holds. `clash_o[i]` pulses for one cycle on entry to that state, in the cycle in which a latch update would have appeared, and stays 0 while the state persists.
- R8: Bit i of each vector port belongs to channel i, and the channels act independently of each other.
- R9: A synchronous reset in the same cycle as a pending latch update wins: the output takes `RST_LEVEL` with no strobe. Contacts still held after release are then taken up again after the full synchroniser latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| throw_hi_n | input | N_SW | Active-low contact line of the throw that gives output 1, one per channel |
| throw_lo_n | input | N_SW | Active-low contact line of the throw that gives output 0, one per channel |
| level_o | output | N_SW | Debounced level per channel |
| change_o | output | N_SW | One-cycle strobe on each level transition |
| clash_o | output | N_SW | One-cycle pulse when both contacts of a channel read low |

## Verification
Two events can land on the same clock edge. One is a clash pulse on one channel while another channel takes a new level with its strobe. The other is a synchronous reset arriving just as a contact change leaves the synchroniser. The vector table drives one channel into the clash state while the other makes a throw in the same step. At the update cycle it expects the pulse on one bit and the new level and strobe on the other. A directed test raises reset in the cycle before a pending set reaches the latch. It expects the default level with no strobe, and then a late take-up of the held contact after the synchroniser latency.

// File: rtl/sw2t_pkg.sv
package sw2t_pkg;

   typedef enum logic [1:0] {
      CT_OPEN  = 2'd0,
      CT_HI    = 2'd1,
      CT_LO    = 2'd2,
      CT_CLASH = 2'd3
   } contact_e;

   // Classify one synchronised pair of active-low contact lines.
   function automatic contact_e classify(input logic hi_n, input logic lo_n);
      contact_e k;
      unique case ({hi_n, lo_n})
         2'b11:   k = CT_OPEN;
         2'b01:   k = CT_HI;
         2'b10:   k = CT_LO;
         default: k = CT_CLASH;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/sw2t_sync.sv
module sw2t_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic y
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{IDLE}};
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign y = chain[STAGES-1];

endmodule

// File: rtl/sw2t_latch.sv
module sw2t_latch
   import sw2t_pkg::*;
#(
   parameter logic RST_VAL   = 1'b0,
   parameter bit   STROBE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic hi_n,
   input  logic lo_n,
   output logic level,
   output logic change,
   output logic clash
);

   contact_e kind;
   logic     nxt;
   logic     in_clash;

   always_comb begin
      kind = classify(hi_n, lo_n);
      nxt  = level;
      case (kind)
         CT_HI:   nxt = 1'b1;
         CT_LO:   nxt = 1'b0;
         default: nxt = level;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         level    <= RST_VAL;
         in_clash <= 1'b0;
         clash    <= 1'b0;
      end else begin
         level    <= nxt;
         in_clash <= (kind == CT_CLASH);
         clash    <= (kind == CT_CLASH) && !in_clash;
      end
   end

   generate
      if (STROBE_EN) begin : g_strobe
         logic chg_q;
         always_ff @(posedge clk) begin
            if (rst) chg_q <= 1'b0;
            else     chg_q <= nxt ^ level;
         end
         assign change = chg_q;
      end else begin : g_no_strobe
         assign change = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sw2t_debounce.sv
module sw2t_debounce #(
   parameter int              N_SW        = 2,
   parameter int              SYNC_STAGES = 2,
   parameter logic [N_SW-1:0] RST_LEVEL   = '0,
   parameter bit              STROBE_EN   = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [N_SW-1:0] throw_hi_n,
   input  logic [N_SW-1:0] throw_lo_n,
   output logic [N_SW-1:0] level_o,
   output logic [N_SW-1:0] change_o,
   output logic [N_SW-1:0] clash_o
);

   localparam int LATENCY = SYNC_STAGES + 1;

   generate
      if (N_SW < 1) begin : g_bad_nsw
         $error("sw2t_debounce: N_SW must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sw2t_debounce: SYNC_STAGES must be at least 2");
      end
      if (LATENCY > 16) begin : g_bad_lat
         $error("sw2t_debounce: synchroniser deeper than supported");
      end
   endgenerate

   logic [N_SW-1:0] hi_n_s;
   logic [N_SW-1:0] lo_n_s;

   generate
      for (genvar i = 0; i < N_SW; i++) begin : g_ch
         sw2t_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_hi (
            .clk (clk),
            .rst (rst),
            .d   (throw_hi_n[i]),
            .y   (hi_n_s[i])
         );
         sw2t_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_lo (
            .clk (clk),
            .rst (rst),
            .d   (throw_lo_n[i]),
            .y   (lo_n_s[i])
         );
         sw2t_latch #(.RST_VAL(RST_LEVEL[i]), .STROBE_EN(STROBE_EN)) u_latch (
            .clk    (clk),
            .rst    (rst),
            .hi_n   (hi_n_s[i]),
            .lo_n   (lo_n_s[i]),
            .level  (level_o[i]),
            .change (change_o[i]),
            .clash  (clash_o[i])
         );
      end
   endgenerate

endmodule

// File: rtl/sw2t_debounce_chk.sv
module sw2t_debounce_chk #(
   parameter int              N_SW      = 2,
   parameter logic [N_SW-1:0] RST_LEVEL = '0,
   parameter bit              STROBE_EN = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic [N_SW-1:0] hi_s,
   input logic [N_SW-1:0] lo_s,
   input logic [N_SW-1:0] level,
   input logic [N_SW-1:0] change,
   input logic [N_SW-1:0] clash
);

   logic seen_rst = 1'b0;
   always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

   // R1: the cycle after a reset edge shows the default state
   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      (seen_rst && $past(rst)) |-> (level == RST_LEVEL && change == '0 && clash == '0));

   generate
      for (genvar i = 0; i < N_SW; i++) begin : g_ch
         // R2, R8
         a_r2_hi_sets: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            (!hi_s[i] && lo_s[i]) |=> level[i]);
         // R3, R8
         a_r3_lo_clears: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            (hi_s[i] && !lo_s[i]) |=> !level[i]);
         // R4
         a_r4_open_holds: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            (hi_s[i] && lo_s[i]) |=> $stable(level[i]));
         // R7
         a_r7_clash_holds: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            (!hi_s[i] && !lo_s[i]) |=> $stable(level[i]));
         a_r7_clash_cause: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            clash[i] |-> $past(!hi_s[i] && !lo_s[i]));
         a_r7_clash_single: assert property (@(posedge clk) disable iff (rst || !seen_rst)
            clash[i] |=> !clash[i]);
         if (STROBE_EN) begin : g_strobe_chk
            // R6
            a_r6_strobe_on_change: assert property (@(posedge clk) disable iff (rst || !seen_rst)
               !$stable(level[i]) |-> change[i]);
            a_r6_strobe_only_change: assert property (@(posedge clk) disable iff (rst || !seen_rst)
               change[i] |-> !$stable(level[i]));
         end
      end
   endgenerate

endmodule

bind sw2t_debounce sw2t_debounce_chk #(
   .N_SW      (N_SW),
   .RST_LEVEL (RST_LEVEL),
   .STROBE_EN (STROBE_EN)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .hi_s   (hi_n_s),
   .lo_s   (lo_n_s),
   .level  (level_o),
   .change (change_o),
   .clash  (clash_o)
);

// File: tb/sw2t_debounce_test.sv
module sw2t_debounce_test;

   localparam int         N    = 2;
   localparam logic [1:0] RSTV = 2'b10;
   localparam int         NV   = 14;

   // Each entry: {throw_hi_n, throw_lo_n, exp level, exp change, exp clash}, bit1 = channel 1.
   localparam logic [9:0] VEC [NV] = '{
      10'b11_11_10_00_00,  // idle, reset level kept (R4)
      10'b10_11_11_01_00,  // ch0 makes high throw (R2, R6)
      10'b11_11_11_00_00,  // ch0 bounces open (R4)
      10'b10_11_11_00_00,  // ch0 recontacts same throw (R5)
      10'b11_01_01_10_00,  // ch1 makes low throw, ch0 open (R3, R8)
      10'b11_10_00_01_00,  // ch0 low, ch1 bounces open (R3, R8)
      10'b11_11_00_00_00,  // all open (R4)
      10'b11_01_00_00_00,  // ch1 recontacts low (R5)
      10'b10_00_00_00_01,  // ch0 both low: clash pulse (R7)
      10'b10_00_00_00_00,  // clash persists: no second pulse (R7)
      10'b10_01_01_01_00,  // ch0 leaves clash to high (R2)
      10'b00_10_11_10_01,  // ch1 set and ch0 clash same cycle (R7, R8)
      10'b11_11_11_00_00,  // all open (R4)
      10'b01_00_10_01_10   // ch0 low, ch1 clash same cycle (R3, R7, R8)
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] hi_n = '1;
   logic [N-1:0] lo_n = '1;
   logic [N-1:0] level_o, change_o, clash_o;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   sw2t_debounce #(.N_SW(N), .SYNC_STAGES(2), .RST_LEVEL(RSTV), .STROBE_EN(1'b1)) uut (
      .clk        (clk),
      .rst        (rst),
      .throw_hi_n (hi_n),
      .throw_lo_n (lo_n),
      .level_o    (level_o),
      .change_o   (change_o),
      .clash_o    (clash_o)
   );

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [1:0] prev;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 level in reset", level_o, RSTV);
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R1 level after reset", level_o, RSTV);
      check("R1 change after reset", change_o, 2'b00);
      check("R1 clash after reset", clash_o, 2'b00);

      prev = RSTV;
      for (int v = 0; v < NV; v++) begin
         hi_n = VEC[v][9:8];
         lo_n = VEC[v][7:6];
         @(posedge clk);
         @(posedge clk);
         @(negedge clk);
         check("R2 latency, old level one edge early", level_o, prev);
         @(posedge clk);
         @(negedge clk);
         check("R2,R3,R4,R5,R8 level", level_o, VEC[v][5:4]);
         check("R6 change strobe", change_o, VEC[v][3:2]);
         check("R7 clash pulse", clash_o, VEC[v][1:0]);
         prev = VEC[v][5:4];
      end
      // R6: strobe gone one cycle after the last transition
      @(posedge clk);
      @(negedge clk);
      check("R6 strobe single cycle", change_o, 2'b00);

      // R9: reset coincides with a pending set on ch0 (level currently 10)
      hi_n = 2'b10;
      lo_n = 2'b11;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R9 reset wins level", level_o, RSTV);
      check("R9 reset wins no strobe", change_o, 2'b00);
      rst = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check("R9 held contact not yet taken", level_o, RSTV);
      @(posedge clk);
      @(negedge clk);
      check("R9 held contact taken up", level_o, 2'b11);
      check("R9 strobe on take-up", change_o, 2'b01);

      hi_n = '1;
      lo_n = '1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R4 open after take-up holds", level_o, 2'b11);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule